// File: doc/BRIEF.md
# Triggered Transient Capture Buffer

This block keeps a rolling record of the most recent window of multi-channel sensor samples. Each accepted frame holds one 10-bit sample per channel, all taken at the same time. Frames go into a circular store of `DEPTH` time slots. While it records, the block passes every `DECIM`-th frame to a monitor output. A supervising controller can watch this thinned stream at low cost and decide when something interesting has happened.

When the controller or a trigger unit raises the dump request, recording freezes. The block then streams the stored window out through a ready/valid port, from the oldest time slot to the newest. Within each time slot it sends channel 0 first and then each following channel in turn, and every word carries its channel number. Frames that arrive during the dump are lost. A saturating counter records how many were dropped, and the controller clears it with an acknowledge pulse.

The target configuration is four channels at 5 MHz with a 2 ms window. That gives `DEPTH` = 10000 and `DECIM` = 100, and 4 × 10000 × 10 bits fits within a 50 kB budget. The default `DEPTH` is kept smaller so that elaboration stays light. Recording resumes on the cycle after the final word is accepted.

Top module: `transient_capture`

## Requirements
- R1: After reset, `rd_valid`, `mon_valid`, `busy` and `drop_cnt` are all zero.
- R2: While recording, `mon_valid` pulses for one cycle after every `DECIM`-th accepted frame, and `mon_data` carries that frame.
- R3: A dump request while recording, with at least one frame stored, freezes the store and reads out the stored time slots oldest first. Once more than `DEPTH` frames have been accepted, this is exactly the last `DEPTH` frames.
- R4: With fewer than `DEPTH` frames stored, the readout starts at the first frame accepted and holds exactly the stored count. A dump request with nothing stored is ignored.
- R5: Each time slot is sent as `NUM_CH` words with `rd_chan` = 0,1,…,`NUM_CH`-1. Channel c sits at bits [c*10 +: 10] of `smp_data`. `rd_last` is 1 only on the final word of the dump.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_data`, `rd_chan` and `rd_last` hold steady.
- R7: Frames presented while `busy` is high are not stored. Each one increments `drop_cnt`, which saturates at all ones, and `drop_flag` is high while `drop_cnt` is non-zero. A `drop_ack` pulse clears the counter on the next cycle.
- R8: A dump request that arrives while a dump is in progress has no effect. No second readout follows.
- R9: No monitor pulse occurs during a dump. The decimation count restarts from zero after the dump, so the first monitor pulse comes on the `DECIM`-th frame accepted after it.
- R10: After a dump, recording continues into the same store. A later window can therefore mix frames from before and after the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A frame is present this cycle |
| smp_data | input | NUM_CH*SW | One sample per channel, channel c at [c*SW +: SW] |
| dump_req | input | 1 | Request to freeze and read out the window |
| mon_valid | output | 1 | Decimated monitor frame valid (one-cycle pulse) |
| mon_data | output | NUM_CH*SW | Decimated monitor frame |
| rd_valid | output | 1 | Readout word valid |
| rd_ready | input | 1 | Readout word accepted |
| rd_data | output | SW | Readout sample |
| rd_chan | output | $clog2(NUM_CH) | Channel tag of the readout sample |
| rd_last | output | 1 | Final word of the dump |
| busy | output | 1 | Dump in progress, recording frozen |
| drop_ack | input | 1 | Clears the dropped-frame counter |
| drop_cnt | output | DROP_W | Saturating count of frames lost during dumps |
| drop_flag | output | 1 | Counter is non-zero |

## Verification
The bench first runs a dump on an empty store. It then dumps a partly filled store, which checks that the readout starts at slot zero rather than at the write pointer. Next it overfills the store so the pointer wraps before a dump, which checks that the oldest-first order follows the wrap. That dump is read with an irregular `rd_ready` pattern, and frames plus a second dump request are injected during it. This separates correct hold-under-backpressure, drop counting and saturation from a design that keeps writing or restarts the readout. A final short recording after the dump shows that the monitor count restarts and that the next window mixes old and new frames.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_REC  = 2'd0,
    ST_LOAD = 2'd1,
    ST_SEND = 2'd2
  } rd_state_t;
endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int DEPTH = 1000,
  parameter int DW    = 40,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cap_monitor.sv
module cap_monitor #(
  parameter int NUM_CH = 4,
  parameter int SW     = 10,
  parameter int DECIM  = 100,
  localparam int FW    = NUM_CH * SW,
  localparam int DCW   = $clog2(DECIM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          busy,
  input  logic [FW-1:0] frame,
  output logic          mon_valid,
  output logic [FW-1:0] mon_data
);
  localparam logic [DCW-1:0] DLAST = DCW'(DECIM - 1);
  logic [DCW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt      <= '0;
      mon_valid <= 1'b0;
      mon_data  <= '0;
    end else begin
      mon_valid <= 1'b0;
      if (busy) begin
        dcnt <= '0;
      end else if (wr_en) begin
        if (dcnt == DLAST) begin
          dcnt      <= '0;
          mon_valid <= 1'b1;
          mon_data  <= frame;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  // R2: with DECIM of at least 2, two monitor pulses never come back to back
  assert_mon_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    mon_valid |=> !mon_valid);

  // R9: no monitor pulse while a dump is in progress
  assert_no_mon_in_dump_R9: assert property (@(posedge clk) disable iff (rst)
    mon_valid |-> !busy);
endmodule

// File: rtl/cap_reader.sv
module cap_reader
  import cap_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SW     = 10,
  parameter int DEPTH  = 1000,
  localparam int FW    = NUM_CH * SW,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [CNTW-1:0] count,
  input  logic [FW-1:0]   rdata,
  output logic [AW-1:0]   raddr,
  output logic            busy,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [SW-1:0]   rd_data,
  output logic [CW-1:0]   rd_chan,
  output logic            rd_last
);
  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CH - 1);
  localparam logic [AW-1:0] TOP     = AW'(DEPTH - 1);

  rd_state_t       state;
  logic [CNTW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_REC;
      raddr   <= '0;
      remain  <= '0;
      rd_chan <= '0;
    end else begin
      case (state)
        ST_REC: begin
          if (start) begin
            raddr   <= start_addr;
            remain  <= count;
            rd_chan <= '0;
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: state <= ST_SEND;
        ST_SEND: begin
          if (rd_ready) begin
            if (rd_chan == LAST_CH) begin
              rd_chan <= '0;
              if (remain == CNTW'(1)) begin
                state <= ST_REC;
              end else begin
                remain <= remain - 1'b1;
                raddr  <= (raddr == TOP) ? '0 : raddr + 1'b1;
                state  <= ST_LOAD;
              end
            end else begin
              rd_chan <= rd_chan + 1'b1;
            end
          end
        end
        default: state <= ST_REC;
      endcase
    end
  end

  assign busy     = (state != ST_REC);
  assign rd_valid = (state == ST_SEND);
  assign rd_data  = rdata[int'(rd_chan) * SW +: SW];
  assign rd_last  = rd_valid && (rd_chan == LAST_CH) && (remain == CNTW'(1));

  // R6: a stalled word holds steady
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_chan)
                                 && $stable(rd_last)));

  // R5: within a time slot the channel tag steps by one
  assert_chan_step_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && rd_chan != LAST_CH) |=>
      (rd_valid && rd_chan == $past(rd_chan) + 1'b1));

  // R3: the dump ends after its last word
  assert_last_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && rd_last) |=> !busy);
endmodule

// File: rtl/transient_capture.sv
module transient_capture #(
  parameter int NUM_CH = 4,
  parameter int SW     = 10,
  parameter int DEPTH  = 1000,
  parameter int DECIM  = 100,
  parameter int DROP_W = 16,
  localparam int FW    = NUM_CH * SW,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [FW-1:0]     smp_data,
  input  logic              dump_req,
  output logic              mon_valid,
  output logic [FW-1:0]     mon_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [SW-1:0]     rd_data,
  output logic [CW-1:0]     rd_chan,
  output logic              rd_last,
  output logic              busy,
  input  logic              drop_ack,
  output logic [DROP_W-1:0] drop_cnt,
  output logic              drop_flag
);
  localparam logic [AW-1:0]     TOP      = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0]   FULL     = CNTW'(DEPTH);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [AW-1:0]   wptr;
  logic [CNTW-1:0] fill;
  logic [AW-1:0]   raddr;
  logic [FW-1:0]   rdata;
  logic            dump_go;
  logic            wr_en;

  assign dump_go = dump_req && !busy && (fill != '0);
  assign wr_en   = smp_valid && !busy && !dump_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      fill <= '0;
    end else if (wr_en) begin
      wptr <= (wptr == TOP) ? '0 : wptr + 1'b1;
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || drop_ack) begin
      drop_cnt <= '0;
    end else if (smp_valid && !wr_en && drop_cnt != DROP_MAX) begin
      drop_cnt <= drop_cnt + 1'b1;
    end
  end
  assign drop_flag = (drop_cnt != '0);

  cap_ram #(.DEPTH(DEPTH), .DW(FW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wptr),
    .wdata (smp_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  cap_monitor #(.NUM_CH(NUM_CH), .SW(SW), .DECIM(DECIM)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .busy      (busy),
    .frame     (smp_data),
    .mon_valid (mon_valid),
    .mon_data  (mon_data)
  );

  cap_reader #(.NUM_CH(NUM_CH), .SW(SW), .DEPTH(DEPTH)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .start      (dump_go),
    .start_addr ((fill == FULL) ? wptr : '0),
    .count      (fill),
    .rdata      (rdata),
    .raddr      (raddr),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .rd_chan    (rd_chan),
    .rd_last    (rd_last)
  );

  // R7: the write pointer is frozen for the whole dump
  assert_wptr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wptr));

  // R7: an acknowledge empties the drop counter
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    drop_ack |=> (drop_cnt == '0));
endmodule

// File: tb/transient_capture_test.sv
module transient_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH    = 4;
  localparam int SW     = 10;
  localparam int DEPTH  = 8;
  localparam int DECIM  = 3;
  localparam int DROP_W = 2;
  localparam int FW     = NCH * SW;
  localparam int CW     = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              rst = 1'b1;
  logic              smp_valid = 1'b0;
  logic [FW-1:0]     smp_data = '0;
  logic              dump_req = 1'b0;
  logic              mon_valid;
  logic [FW-1:0]     mon_data;
  logic              rd_valid;
  logic              rd_ready = 1'b1;
  logic [SW-1:0]     rd_data;
  logic [CW-1:0]     rd_chan;
  logic              rd_last;
  logic              busy;
  logic              drop_ack = 1'b0;
  logic [DROP_W-1:0] drop_cnt;
  logic              drop_flag;

  transient_capture #(.NUM_CH(NCH), .SW(SW), .DEPTH(DEPTH), .DECIM(DECIM), .DROP_W(DROP_W)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data), .dump_req(dump_req),
    .mon_valid(mon_valid), .mon_data(mon_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_chan(rd_chan), .rd_last(rd_last), .busy(busy),
    .drop_ack(drop_ack), .drop_cnt(drop_cnt), .drop_flag(drop_flag)
  );

  int checks = 0;
  int errors = 0;
  int fno = 0;
  int dcnt = 0;
  bit ready_rand = 1'b0;
  string phase = "R3";
  logic [FW-1:0]   hist[$];
  logic [SW+CW:0]  rq[$];
  logic [FW-1:0]   mq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk_frame(input int n);
    logic [FW-1:0] f;
    for (int c = 0; c < NCH; c++) f[c*SW +: SW] = SW'(n * NCH + c + 1);
    return f;
  endfunction

  // driver: present one frame and update the reference model if it is stored
  task automatic push_frame(input bit stored);
    logic [FW-1:0] f;
    f = mk_frame(fno);
    @(negedge clk);
    smp_valid <= 1'b1;
    smp_data  <= f;
    if (stored) begin
      hist.push_back(f);
      if (hist.size() > DEPTH) void'(hist.pop_front());
      if (dcnt == DECIM - 1) begin
        mq.push_back(f);
        dcnt = 0;
      end else begin
        dcnt++;
      end
    end
    fno++;
  endtask

  task automatic stop_frames();
    @(negedge clk);
    smp_valid <= 1'b0;
  endtask

  task automatic do_dump();
    @(negedge clk);
    dump_req <= 1'b1;
    for (int i = 0; i < hist.size(); i++)
      for (int c = 0; c < NCH; c++)
        rq.push_back({(i == hist.size() - 1 && c == NCH - 1), CW'(c), hist[i][c*SW +: SW]});
    dcnt = 0;
    @(negedge clk);
    dump_req <= 1'b0;
  endtask

  task automatic wait_drain(input string req);
    wait (rq.size() == 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, req, "busy after dump", busy, 0);
    check(rd_valid == 1'b0, req, "rd_valid after dump", rd_valid, 0);
  endtask

  // monitor: compare readout words and monitor frames as they appear
  initial begin
    logic [SW+CW:0] e;
    forever begin
      @(negedge clk);
      rd_ready <= ready_rand ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (!rst && rd_valid && rd_ready) begin
        if (rq.size() == 0) begin
          check(1'b0, "R8", "unexpected readout word", rd_data, 0);
        end else begin
          e = rq.pop_front();
          check(rd_data == e[SW-1:0], phase, "rd_data", rd_data, e[SW-1:0]);
          check(rd_chan == e[SW+CW-1:SW], "R5", "rd_chan", rd_chan, e[SW+CW-1:SW]);
          check(rd_last == e[SW+CW], "R5", "rd_last", rd_last, e[SW+CW]);
        end
      end
      if (!rst && mon_valid) begin
        if (mq.size() == 0) check(1'b0, "R9", "unexpected monitor pulse", mon_data, 0);
        else begin
          logic [FW-1:0] m;
          m = mq.pop_front();
          check(mon_data == m, "R2", "mon_data", mon_data, m);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
    check(mon_valid == 1'b0, "R1", "mon_valid", mon_valid, 0);
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(drop_cnt == '0, "R1", "drop_cnt", drop_cnt, 0);

    // R4: dump with an empty store is ignored
    do_dump();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(busy == 1'b0 && rd_valid == 1'b0, "R4", "empty dump ignored", busy, 0);
    end

    // R4: partial window, readout from slot zero; R2 monitor on the third frame
    phase = "R4";
    for (int i = 0; i < 5; i++) push_frame(1'b1);
    stop_frames();
    repeat (2) @(negedge clk);
    do_dump();
    wait_drain("R4");
    check(mq.size() == 0, "R2", "monitor frames pending", mq.size(), 0);

    // R3 R6: wrapped window under irregular ready, R7 drops, R8 repeat request
    phase = "R3";
    ready_rand = 1'b1;
    for (int i = 0; i < 21; i++) push_frame(1'b1);
    stop_frames();
    do_dump();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) push_frame(1'b0);
    stop_frames();
    check(busy == 1'b1, "R8", "still dumping", busy, 1);
    @(negedge clk);
    dump_req <= 1'b1;
    @(negedge clk);
    dump_req <= 1'b0;
    wait_drain("R8");
    ready_rand = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rd_valid == 1'b0, "R8", "no second readout", rd_valid, 0);
    end
    check(drop_cnt == 2'd3, "R7", "drop_cnt saturated", drop_cnt, 3);
    check(drop_flag == 1'b1, "R7", "drop_flag", drop_flag, 1);
    @(negedge clk);
    drop_ack <= 1'b1;
    @(negedge clk);
    drop_ack <= 1'b0;
    check(drop_cnt == '0, "R7", "drop_cnt cleared", drop_cnt, 0);
    check(drop_flag == 1'b0, "R7", "drop_flag cleared", drop_flag, 0);

    // R9 R10: monitor count restarts; next window mixes old and new frames
    phase = "R10";
    for (int i = 0; i < 4; i++) push_frame(1'b1);
    stop_frames();
    repeat (2) @(negedge clk);
    check(mq.size() == 0, "R9", "monitor after restart", mq.size(), 0);
    do_dump();
    wait_drain("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule